// File: doc/BRIEF.md
# Amplifier Mute and Protection Controller

This block supervises the output stage of a multi-channel switching power amplifier. It takes a mute request, over-voltage and under-voltage flags for the supply rails, one over-current flag for each output transistor, and one input-overload flag for each channel. From these it produces the gate-drive enables for the high-side and low-side transistors of every channel, an active-high "stages off" status, and an active-low overload indicator.

Supply faults are self-clearing. Over-current events are held in a latch until the mute request is asserted while no over-current flag is active, or until reset. Whenever the block leaves a disabled state, whether from mute, a supply fault, a cleared over-current latch or reset, the enables stay off until a fixed release delay has run out. That delay is a parameter counted in clock cycles. All asynchronous inputs pass through synchronizer chains first.

Top module: `amp_guard`

## Requirements
- R1: While `rst` is high, and on the clock edges that follow it, every drive enable is 0, `stage_off` is 1 and `ovl_n` is 1, whatever the inputs are.
- R2: A high `mute_req` turns off both the high-side and the low-side enable of every channel and sets `stage_off` to 1 within 3 clock edges after the input changes.
- R3: Count the clock edges after the last disabling condition clears at the inputs. The enables stay 0 through edge RELEASE_CYCLES+1 and become 1 at edge RELEASE_CYCLES+2. Any disabling condition during the count restarts it.
- R4: A high `supply_ov` or `supply_uv` disables all outputs within 3 edges. Once both flags are low, the outputs return on their own through the R3 release delay, with no mute needed.
- R5: A high bit in `oc_flags` disables all channels within 3 edges, and the condition is latched. Bit 2c is the high-side transistor of channel c and bit 2c+1 is its low-side transistor. The outputs stay off after the flag drops.
- R6: The over-current latch clears only while the synchronized mute request is high and no `oc_flags` bit is set. After mute is released, the R3 delay applies.
- R7: `ovl_n` is 0 exactly while at least one `ovl_flags` bit is 1, with a 3-edge latency and no latching. `ovl_flags` has no effect on the drive enables or on `stage_off`.
- R8: `drv_en_hi` and `drv_en_lo` are equal, every channel bit carries the same value, and `stage_off` is the complement of that value.
- R9: A reset clears the over-current latch and starts the release delay. The outputs come on at the RELEASE_CYCLES-th edge after reset falls if no condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | Asynchronous mute request, high mutes all channels |
| supply_ov | input | 1 | Asynchronous supply over-voltage flag |
| supply_uv | input | 1 | Asynchronous supply under-voltage flag |
| oc_flags | input | 2*NCH | Over-current flags, bit 2c high side and bit 2c+1 low side of channel c |
| ovl_flags | input | NCH | Per-channel input overload flags |
| drv_en_hi | output | NCH | High-side gate drive enable per channel |
| drv_en_lo | output | NCH | Low-side gate drive enable per channel |
| stage_off | output | 1 | High while the output stages are off |
| ovl_n | output | 1 | Low while any channel is overloaded |

## Verification
A latch stuck set shows up as `stage_off` remaining high long after the release delay, even though every input is quiet. A latch that clears without mute shows up as the enables returning about RELEASE_CYCLES edges after an over-current pulse. A wrong release counter moves the rising edge of the enables away from edge RELEASE_CYCLES+2, so the bench samples on both sides of that edge. A crossed overload or enable path changes `ovl_n` or `stage_off` within three edges of the stimulus.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_COUNT = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/amp_guard_sync.sv
module amp_guard_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/amp_guard_oc_latch.sv
module amp_guard_oc_latch #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] oc_s,
  input  logic             mute_s,
  output logic             latched,
  output logic             trip
);
  logic [NFLAG-1:0] lat_q;
  logic             any_flag;
  logic             clr_ok;

  assign any_flag = |oc_s;
  assign clr_ok   = mute_s & ~any_flag;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          lat_q[i] <= 1'b0;
      else if (oc_s[i]) lat_q[i] <= 1'b1;
      else if (clr_ok)  lat_q[i] <= 1'b0;
    end
  end

  assign latched = |lat_q;
  assign trip    = latched | any_flag;
endmodule

// File: rtl/amp_guard_release.sv
module amp_guard_release
  import amp_guard_pkg::*;
#(
  parameter int RELEASE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic run_q,
  output logic off_q
);
  localparam int CW = cnt_width(RELEASE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase <= PH_HOLD;
      cnt   <= '0;
      run_q <= 1'b0;
      off_q <= 1'b1;
    end else begin
      case (phase)
        PH_HOLD, PH_COUNT: begin
          if (cnt == LAST) begin
            phase <= PH_RUN;
            run_q <= 1'b1;
            off_q <= 1'b0;
          end else begin
            phase <= PH_COUNT;
            cnt   <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_RUN;
          run_q <= 1'b1;
          off_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/amp_guard.sv
module amp_guard #(
  parameter int NCH            = 2,
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_CYCLES = 20_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mute_req,
  input  logic             supply_ov,
  input  logic             supply_uv,
  input  logic [2*NCH-1:0] oc_flags,
  input  logic [NCH-1:0]   ovl_flags,
  output logic [NCH-1:0]   drv_en_hi,
  output logic [NCH-1:0]   drv_en_lo,
  output logic             stage_off,
  output logic             ovl_n
);
  localparam int NOC = 2 * NCH;
  localparam int SW  = 3 + NOC + NCH;

  logic [SW-1:0]  raw_bus, syn_bus;
  logic           s_mute, s_ov, s_uv;
  logic [NOC-1:0] s_oc;
  logic [NCH-1:0] s_ovl;
  logic           oc_lat, oc_trip;
  logic           hold;
  logic           run_q, off_q;
  logic           ovl_n_q;

  assign raw_bus = {ovl_flags, oc_flags, supply_uv, supply_ov, mute_req};

  amp_guard_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign s_mute = syn_bus[0];
  assign s_ov   = syn_bus[1];
  assign s_uv   = syn_bus[2];
  assign s_oc   = syn_bus[3 +: NOC];
  assign s_ovl  = syn_bus[3 + NOC +: NCH];

  amp_guard_oc_latch #(.NFLAG(NOC)) u_ocl (
    .clk(clk), .rst(rst), .oc_s(s_oc), .mute_s(s_mute),
    .latched(oc_lat), .trip(oc_trip)
  );

  assign hold = s_mute | s_ov | s_uv | oc_trip;

  amp_guard_release #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_rel (
    .clk(clk), .rst(rst), .hold(hold), .run_q(run_q), .off_q(off_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ovl_n_q <= 1'b1;
    else     ovl_n_q <= ~(|s_ovl);
  end

  assign drv_en_hi = {NCH{run_q}};
  assign drv_en_lo = {NCH{run_q}};
  assign stage_off = off_q;
  assign ovl_n     = ovl_n_q;
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           mute_req,
  input logic           stage_off,
  input logic [NCH-1:0] drv_en_hi,
  input logic           s_mute,
  input logic           s_ov,
  input logic           s_uv,
  input logic           oc_lat,
  input logic           hold
);
  AST_MUTE_OFF: assert property (@(posedge clk) disable iff (rst)
    (mute_req && $past(mute_req) && $past(mute_req, 2)) |=> stage_off); // R2

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en_hi[0]) |-> $past(!hold)); // R3

  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(s_ov || s_uv) |-> stage_off); // R4

  AST_OC_OFF: assert property (@(posedge clk) disable iff (rst)
    oc_lat |-> stage_off); // R5

  AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(oc_lat) && !$past(s_mute)) |-> oc_lat); // R5

  AST_OC_CLEAR_BY_MUTE: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_lat) |-> $past(s_mute)); // R6
endmodule

bind amp_guard amp_guard_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .mute_req(mute_req), .stage_off(stage_off),
  .drv_en_hi(drv_en_hi), .s_mute(s_mute), .s_ov(s_ov), .s_uv(s_uv),
  .oc_lat(oc_lat), .hold(hold)
);

// File: tb/amp_guard_test.sv
module amp_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int DELAY = 20;

  logic           clk = 1'b0;
  logic           rst;
  logic           mute_req, supply_ov, supply_uv;
  logic [3:0]     oc_flags;
  logic [1:0]     ovl_flags;
  logic [NCH-1:0] drv_en_hi, drv_en_lo;
  logic           stage_off, ovl_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_guard #(.NCH(NCH), .SYNC_STAGES(2), .RELEASE_CYCLES(DELAY)) uut (
    .clk(clk), .rst(rst), .mute_req(mute_req), .supply_ov(supply_ov),
    .supply_uv(supply_uv), .oc_flags(oc_flags), .ovl_flags(ovl_flags),
    .drv_en_hi(drv_en_hi), .drv_en_lo(drv_en_lo),
    .stage_off(stage_off), .ovl_n(ovl_n)
  );

  typedef struct packed {
    logic       mute;
    logic       ov;
    logic       uv;
    logic [3:0] oc;
    logic [1:0] ovl;
    logic [7:0] wait_n;
    logic       exp_off;
    logic       exp_ovn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd30,1'b0,1'b1,4'd3},
    '{1'b0,1'b0,1'b0,4'b0000,2'b01,8'd5, 1'b0,1'b0,4'd7},
    '{1'b0,1'b0,1'b0,4'b0000,2'b10,8'd5, 1'b0,1'b0,4'd7},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd5, 1'b0,1'b1,4'd7},
    '{1'b1,1'b0,1'b0,4'b0000,2'b00,8'd5, 1'b1,1'b1,4'd2},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd19,1'b1,1'b1,4'd3},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd4, 1'b0,1'b1,4'd3},
    '{1'b0,1'b1,1'b0,4'b0000,2'b00,8'd5, 1'b1,1'b1,4'd4},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd19,1'b1,1'b1,4'd4},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd4, 1'b0,1'b1,4'd4},
    '{1'b0,1'b0,1'b1,4'b0000,2'b00,8'd5, 1'b1,1'b1,4'd4},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd10,1'b1,1'b1,4'd3},
    '{1'b0,1'b1,1'b0,4'b0000,2'b00,8'd5, 1'b1,1'b1,4'd3},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd30,1'b0,1'b1,4'd3},
    '{1'b0,1'b0,1'b0,4'b0001,2'b00,8'd5, 1'b1,1'b1,4'd5},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd40,1'b1,1'b1,4'd5},
    '{1'b1,1'b0,1'b0,4'b0000,2'b11,8'd5, 1'b1,1'b0,4'd7},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd30,1'b0,1'b1,4'd6},
    '{1'b0,1'b0,1'b0,4'b1000,2'b00,8'd5, 1'b1,1'b1,4'd5},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd40,1'b1,1'b1,4'd5},
    '{1'b1,1'b0,1'b0,4'b0100,2'b00,8'd5, 1'b1,1'b1,4'd6},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd30,1'b1,1'b1,4'd6},
    '{1'b1,1'b0,1'b0,4'b0000,2'b00,8'd5, 1'b1,1'b1,4'd6},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd30,1'b0,1'b1,4'd6},
    '{1'b0,1'b0,1'b0,4'b0010,2'b01,8'd5, 1'b1,1'b0,4'd5},
    '{1'b0,1'b0,1'b0,4'b0000,2'b00,8'd40,1'b1,1'b1,4'd5}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic exp_off, input logic exp_ovn);
    logic [NCH-1:0] en_exp;
    en_exp = {NCH{~exp_off}};
    check(req, "stage_off", {7'd0, stage_off}, {7'd0, exp_off});
    check(req, "ovl_n", {7'd0, ovl_n}, {7'd0, exp_ovn});
    check("R8", "drv_en_hi", {6'd0, drv_en_hi}, {6'd0, en_exp});
    check("R8", "drv_en_lo", {6'd0, drv_en_lo}, {6'd0, en_exp});
  endtask

  task automatic run_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mute_req = 1'b0; supply_ov = 1'b0; supply_uv = 1'b0;
    oc_flags = '0; ovl_flags = 2'b11;
    run_edges(4);
    check_outs("R1", 1'b1, 1'b1);       // R1: overload ignored in reset
    ovl_flags = '0;
    run_edges(1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      mute_req  = VEC[i].mute;
      supply_ov = VEC[i].ov;
      supply_uv = VEC[i].uv;
      oc_flags  = VEC[i].oc;
      ovl_flags = VEC[i].ovl;
      run_edges(int'(VEC[i].wait_n));
      check_outs(req_name(VEC[i].req), VEC[i].exp_off, VEC[i].exp_ovn);
    end

    // R9: latch an over-current event, then reset clears it
    oc_flags = 4'b0100;
    run_edges(5);
    oc_flags = 4'b0000;
    run_edges(10);
    check_outs("R5", 1'b1, 1'b1);
    rst = 1'b1;
    run_edges(3);
    check_outs("R1", 1'b1, 1'b1);
    rst = 1'b0;
    run_edges(DELAY - 2);
    check_outs("R9", 1'b1, 1'b1);
    run_edges(4);
    check_outs("R9", 1'b0, 1'b1);

    // R3: a short mute pulse during the count restarts the delay
    mute_req = 1'b1;
    run_edges(5);
    mute_req = 1'b0;
    run_edges(10);
    mute_req = 1'b1;
    run_edges(1);
    mute_req = 1'b0;
    run_edges(DELAY);
    check_outs("R3", 1'b1, 1'b1);
    run_edges(4);
    check_outs("R3", 1'b0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule